// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Partial Refill

This block sits between a processor's instruction-fetch port and a word-addressed backing memory. Each accepted fetch returns one 32-bit instruction word. Cacheable fetches are looked up in a direct-mapped array of 256 lines, with four words per line. A miss reads from memory only the missed word and the words above it in the line. Fetches at or above the uncached boundary go to memory as a single read and leave the array untouched.

Each line stores the full fetch address that last refilled it, not a truncated tag. A later fetch to a lower word of the same line is therefore a miss, because that word may never have been loaded. The array is cleared to all ones by a sweep of one line per cycle. The sweep runs after reset and after every cache-isolate pulse. While it runs, no fetch is accepted.

The processor side uses a ready/valid handshake and answers each fetch with a single-cycle response strobe. The memory side has one read outstanding at a time. It issues a request with an address and waits for a response, which either carries data or reports the address as unmapped.

Top module: `fetch_line_cache`

## Requirements
- R1: The array has 256 lines of four 32-bit words. Fetch address bits 11:4 pick the line, so all 256 lines can hold separate data at the same time.
- R2: A fetch address at or above 0xA0000000 makes exactly one memory read at the word-aligned address and returns that word. The array is not changed, so a line cached earlier still hits afterwards.
- R3: A cacheable fetch hits only if the stored address equals the fetch address in bits 31:4 and the fetch address is not below the stored address. A hit makes no memory read.
- R4: On a miss, the full fetch address becomes the line's stored address. The words from the fetch's word offset up to word 3 are read, at consecutive ascending addresses. This is 4 minus the offset reads, and lower words are not written.
- R5: Fetch address bits 3:2 select the returned word, both on a hit and on a refill.
- R6: If the first memory response of a miss or a bypass reports the address as unmapped, the fetch returns zero. On a miss, the line is left as it was, so an earlier hit on it still hits.
- R7: After reset, all 256 lines are set to all ones by a sweep. During those 256 cycles `fetchReady` stays low, and afterwards every cacheable fetch misses once.
- R8: A pulse on `isolateReq` clears the whole array in the same way. If it arrives while a fetch is in flight, or in the same cycle a fetch is accepted, that fetch completes first using the old contents. The sweep follows.
- R9: `fetchReady` is low from the cycle after a fetch is accepted until its response. `respValid` is high for exactly one cycle per fetch, and never while `fetchReady` is high.
- R10: `memReq` is high for a single cycle per read, and only one read is outstanding at a time. `memAddr` is always word aligned (bits 1:0 zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset; starts the clearing sweep |
| fetchValid | input | 1 | Fetch request present |
| fetchAddr | input | 32 | Byte address of the instruction word |
| fetchReady | output | 1 | Block can accept a fetch this cycle |
| respValid | output | 1 | One-cycle strobe: `respData` holds the fetched word |
| respData | output | 32 | Returned instruction word |
| isolateReq | input | 1 | One-cycle pulse requesting a full clear |
| memReq | output | 1 | One-cycle read request to memory |
| memAddr | output | 32 | Word-aligned read address |
| memValid | input | 1 | Memory response present |
| memData | input | 32 | Memory read data |
| memErr | input | 1 | Memory response: address unmapped |

## Verification
A clear request can coincide with fetch service in two ways: `isolateReq` in the very cycle a fetch is accepted, or during a refill's memory reads. The bench drives the pulse in both places. It expects the fetch to return the word and read count given by the array contents before the clear. It then expects a sweep stall, followed by a fresh miss at the same address. The scoreboard model applies the clear only after it has recorded the in-flight fetch's expectation, so a design that cleared early or dropped the request fails on data or on read count.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LINES      = 256;
  localparam int LINE_WORDS = 4;
  localparam int BYTE_W     = 2;
  localparam int IDX_W      = $clog2(LINES);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int OFF_LO     = WSEL_W + BYTE_W;

  typedef enum logic [2:0] {
    ST_SWEEP, ST_IDLE, ST_LOOK, ST_FILL_ISS, ST_FILL_WAIT,
    ST_BYP_ISS, ST_BYP_WAIT, ST_RESP
  } ctlState_t;

  typedef struct packed {
    logic              latchReq;
    logic              sweepWr;
    logic [IDX_W-1:0]  sweepLine;
    logic              fillWr;
    logic              tagWr;
    logic [WSEL_W-1:0] wordSel;
    logic              captureHit;
    logic              captureMem;
    logic              zeroResult;
  } dpStrobe_t;
endpackage

// File: rtl/flc_datapath.sv
module flc_datapath
  import flc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] memData,
  input  dpStrobe_t         strobe,
  output logic              hit,
  output logic              cacheable,
  output logic [WSEL_W-1:0] reqWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] respData
);
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] result;
  logic [ADDR_W-1:0] tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][LINE_WORDS];
  logic [IDX_W-1:0]  lineIdx;
  logic [ADDR_W-1:0] storedTag;

  assign lineIdx   = reqAddr[OFF_LO +: IDX_W];
  assign reqWord   = reqAddr[BYTE_W +: WSEL_W];
  assign storedTag = tagMem[lineIdx];
  assign cacheable = reqAddr < UNCACHED_BASE;
  assign hit       = (storedTag[ADDR_W-1:OFF_LO] == reqAddr[ADDR_W-1:OFF_LO])
                     && !(reqAddr < storedTag);
  assign memAddr   = {reqAddr[ADDR_W-1:OFF_LO], strobe.wordSel, {BYTE_W{1'b0}}};
  assign respData  = result;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      result  <= '0;
    end else begin
      if (strobe.latchReq) reqAddr <= fetchAddr;
      if (strobe.captureHit)      result <= dataMem[lineIdx][reqWord];
      else if (strobe.captureMem) result <= memData;
      else if (strobe.zeroResult) result <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.sweepWr) begin
      tagMem[strobe.sweepLine] <= '1;
      for (int w = 0; w < LINE_WORDS; w++) dataMem[strobe.sweepLine][w] <= '1;
    end else begin
      if (strobe.tagWr)  tagMem[lineIdx] <= reqAddr;
      if (strobe.fillWr) dataMem[lineIdx][strobe.wordSel] <= memData;
    end
  end
endmodule

// File: rtl/flc_control.sv
module flc_control
  import flc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic              isolateReq,
  input  logic              memValid,
  input  logic              memErr,
  input  logic              hit,
  input  logic              cacheable,
  input  logic [WSEL_W-1:0] reqWord,
  output logic              fetchReady,
  output logic              respValid,
  output logic              memReq,
  output dpStrobe_t         strobe
);
  ctlState_t         state, nextState;
  logic [IDX_W-1:0]  sweepCnt;
  logic [WSEL_W-1:0] wordCnt;
  logic              isoPend;

  assign fetchReady = (state == ST_IDLE) && !isoPend;
  assign respValid  = (state == ST_RESP);
  assign memReq     = (state == ST_FILL_ISS) || (state == ST_BYP_ISS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_SWEEP;
      sweepCnt <= '0;
      wordCnt  <= '0;
      isoPend  <= 1'b0;
    end else begin
      state <= nextState;
      if (isolateReq) isoPend <= 1'b1;
      else if (state == ST_IDLE && isoPend) isoPend <= 1'b0;
      case (state)
        ST_SWEEP:     sweepCnt <= sweepCnt + 1'b1;
        ST_IDLE:      sweepCnt <= '0;
        ST_LOOK:      wordCnt  <= reqWord;
        ST_FILL_WAIT: if (memValid && !memErr) wordCnt <= wordCnt + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    nextState        = state;
    strobe           = '0;
    strobe.sweepLine = sweepCnt;
    strobe.wordSel   = wordCnt;
    case (state)
      ST_SWEEP: begin
        strobe.sweepWr = 1'b1;
        if (sweepCnt == IDX_W'(LINES - 1)) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (isoPend) nextState = ST_SWEEP;
        else if (fetchValid) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!cacheable) nextState = ST_BYP_ISS;
        else if (hit) begin
          strobe.captureHit = 1'b1;
          nextState         = ST_RESP;
        end else nextState = ST_FILL_ISS;
      end
      ST_FILL_ISS: nextState = ST_FILL_WAIT;
      ST_FILL_WAIT: begin
        if (memValid) begin
          if (memErr) begin
            strobe.zeroResult = 1'b1;
            nextState         = ST_RESP;
          end else begin
            strobe.fillWr = 1'b1;
            if (wordCnt == reqWord) begin
              strobe.tagWr      = 1'b1;
              strobe.captureMem = 1'b1;
            end
            if (wordCnt == WSEL_W'(LINE_WORDS - 1)) nextState = ST_RESP;
            else nextState = ST_FILL_ISS;
          end
        end
      end
      ST_BYP_ISS: nextState = ST_BYP_WAIT;
      ST_BYP_WAIT: begin
        if (memValid) begin
          if (memErr) strobe.zeroResult = 1'b1;
          else        strobe.captureMem = 1'b1;
          nextState = ST_RESP;
        end
      end
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import flc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  input  logic              isolateReq,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr
);
  dpStrobe_t         strobe;
  logic              hit;
  logic              cacheable;
  logic [WSEL_W-1:0] reqWord;

  flc_control u_ctl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .isolateReq(isolateReq),
    .memValid(memValid), .memErr(memErr), .hit(hit), .cacheable(cacheable),
    .reqWord(reqWord), .fetchReady(fetchReady), .respValid(respValid),
    .memReq(memReq), .strobe(strobe)
  );

  flc_datapath #(.UNCACHED_BASE(UNCACHED_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .memData(memData),
    .strobe(strobe), .hit(hit), .cacheable(cacheable), .reqWord(reqWord),
    .memAddr(memAddr), .respData(respData)
  );
endmodule

// File: rtl/flc_checker.sv
module flc_checker
  import flc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic              fetchReady,
  input logic              respValid,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr
);
  logic [IDX_W:0] sinceReset;

  always_ff @(posedge clk) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != (IDX_W+1)'(LINES)) sinceReset <= sinceReset + 1'b1;
  end

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R9
  AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !fetchReady); // R9
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> !fetchReady); // R9
  AST_MEM_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R10
  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R10
  AST_SWEEP_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset < (IDX_W+1)'(LINES)) |-> !fetchReady); // R7
endmodule

bind fetch_line_cache flc_checker u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .respValid(respValid), .memReq(memReq), .memAddr(memAddr)
);

// File: tb/fetch_line_cache_bench.sv
module fetch_line_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady, respValid, memReq;
  logic [31:0] respData, memAddr;
  logic        isolateReq = 1'b0;
  logic        memValid;
  logic [31:0] memData;
  logic        memErr;

  int total = 0;
  int bad = 0;
  int gen = 0;
  int memReqCount = 0;
  int lastReqCount = 0;
  bit prevResp = 1'b0;

  logic [31:0] expQ[$];
  int          readQ[$];
  string       tagQ[$];

  logic [31:0] mTag  [256];
  logic [31:0] mData [256][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_line_cache u_fetch_line_cache (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .respValid(respValid), .respData(respData),
    .isolateReq(isolateReq), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .memErr(memErr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h0BAD_F00D ^ (32'(gen) * 32'h0101_0000);
  endfunction

  function automatic bit unmapped(input logic [31:0] a);
    return (a[31:28] == 4'h1) || (a[31:28] == 4'hE);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memErr   <= 1'b0;
      memData  <= '0;
    end else begin
      memValid <= memReq;
      memErr   <= memReq && unmapped(memAddr);
      memData  <= unmapped(memAddr) ? 32'hFFFF_FFFF : memWord(memAddr);
    end
  end

  always @(posedge clk) if (rstN && memReq) memReqCount++;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rstN) begin
      if (respValid) begin
        check(!prevResp, "R9", "respValid longer than one cycle", 32'(prevResp), 0);
        check(!fetchReady, "R9", "ready high during response", 32'(fetchReady), 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected response", respData, 0);
        end else begin
          automatic logic [31:0] e = expQ.pop_front();
          automatic int r = readQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(respData == e, t, "data", respData, e);
          check((memReqCount - lastReqCount) == r, t, "memory read count",
                32'(memReqCount - lastReqCount), 32'(r));
        end
        lastReqCount = memReqCount;
      end
      prevResp = respValid;
    end
  end

  task automatic modelInvalidate();
    for (int i = 0; i < 256; i++) begin
      mTag[i] = '1;
      for (int w = 0; w < 4; w++) mData[i][w] = '1;
    end
  endtask

  // Driver: computes expectations from the requirements and pushes them
  task automatic doFetch(input logic [31:0] a, input string rq, input bit withIso = 1'b0);
    logic [31:0] e;
    int r;
    int idx;
    int off;
    @(negedge clk);
    while (!fetchReady) @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    isolateReq = withIso;
    idx = int'(a[11:4]);
    off = int'(a[3:2]);
    if (a >= 32'hA000_0000) begin
      r = 1;
      e = unmapped(a) ? 32'h0 : memWord(a);
    end else if (mTag[idx][31:4] == a[31:4] && a >= mTag[idx]) begin
      r = 0;
      e = mData[idx][off];
    end else if (unmapped(a)) begin
      r = 1;
      e = 32'h0;
    end else begin
      mTag[idx] = a;
      for (int w = off; w < 4; w++) mData[idx][w] = memWord({a[31:4], 2'(w), 2'b00});
      r = 4 - off;
      e = mData[idx][off];
    end
    expQ.push_back(e);
    readQ.push_back(r);
    tagQ.push_back(rq);
    if (withIso) modelInvalidate();
    @(negedge clk);
    fetchValid = 1'b0;
    isolateReq = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finishRun();
  end

  initial begin
    int cnt;
    modelInvalidate();
    repeat (3) @(negedge clk);
    check(fetchReady == 1'b0, "R7", "ready in reset", 32'(fetchReady), 0);
    check(respValid == 1'b0, "R9", "respValid in reset", 32'(respValid), 0);
    check(memReq == 1'b0, "R10", "memReq in reset", 32'(memReq), 0);
    rstN = 1'b1;
    cnt = 0;
    while (!fetchReady) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 256, "R7", "sweep length after reset", 32'(cnt), 256);

    // R7 first fetch misses, R1/R5 word selection on hits
    doFetch(32'h0000_0100, "R7");
    doFetch(32'h0000_0104, "R5");
    doFetch(32'h0000_0108, "R5");
    doFetch(32'h0000_010C, "R5");
    // R4 partial refill, R3 lower offset misses
    doFetch(32'h0000_0208, "R4");
    doFetch(32'h0000_020C, "R3");
    doFetch(32'h0000_0200, "R3");
    doFetch(32'h0000_0204, "R3");
    doFetch(32'h0000_030C, "R4");
    drain();
    // R3 stale hit after memory contents change
    gen = 1;
    doFetch(32'h0000_0104, "R3");
    // R3 same index, different upper bits
    doFetch(32'h8000_1104, "R3");
    doFetch(32'h0000_0104, "R3");
    doFetch(32'h8000_1108, "R3");
    // R2 bypass leaves array unchanged
    doFetch(32'hA000_0100, "R2");
    doFetch(32'hBFC0_0004, "R2");
    doFetch(32'h0000_010C, "R2");
    doFetch(32'h9FFF_FFFC, "R2");
    doFetch(32'h9FFF_FFFC, "R2");
    // R6 unmapped miss and bypass
    doFetch(32'h0000_0040, "R6");
    doFetch(32'h1000_0040, "R6");
    doFetch(32'h0000_0044, "R6");
    doFetch(32'hE000_0000, "R6");
    drain();
    // R8 isolate while idle
    @(negedge clk);
    isolateReq = 1'b1;
    modelInvalidate();
    @(negedge clk);
    isolateReq = 1'b0;
    doFetch(32'h0000_0104, "R8");
    doFetch(32'h0000_0108, "R8");
    // R8 isolate during a refill
    doFetch(32'h0000_0300, "R8");
    repeat (2) @(negedge clk);
    isolateReq = 1'b1;
    @(negedge clk);
    isolateReq = 1'b0;
    drain();
    modelInvalidate();
    doFetch(32'h0000_0304, "R8");
    // R8 isolate in the accept cycle
    doFetch(32'h0000_0308, "R8", 1'b1);
    doFetch(32'h0000_0308, "R8");
    drain();
    // R1 every line holds its own data
    for (int i = 0; i < 256; i++) doFetch(32'h4000_0000 + 32'(i) * 16 + 32'(i % 4) * 4, "R1");
    for (int i = 0; i < 256; i++) doFetch(32'h4000_000C + 32'(i) * 16, "R1");
    drain();
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule